// File: doc/BRIEF.md
# Banked GPIO Pin Register File

This block is the software-facing register file for a group of general-purpose pins (18 by default). Through a byte-wide synchronous read/write port, software picks each pin's direction, drives its output level, reads back its input level, and programs per-pin pull-up and pull-down selects and per-pin debounce enables. A small control register holds a module enable and two card-detect enables.

Pin state is spread across 8-bit banks. Pin n lives in bank n>>3 at bit n&7. Output levels can be written directly. They can also be changed through separate write-one-to-set and write-one-to-clear registers, which lets software flip single pins without a read-modify-write. Pull selects take two bits per pin, so four pins fit in each 8-bit register.

Pin inputs pass through a two-flop synchroniser before they can be read. Output enables, levels and pad controls leave the block from flops.

Top module: `gpio_rf_top`

## Requirements
- R1: The direction banks sit at 0x00-0x02. Pin n is bit n&7 of address 0x00+(n>>3). A 1 makes the pin an output. When the module enable is set, pin_oe[n] equals that bit two clock edges after the write.
- R2: The input banks at 0x03-0x05 are read-only. They return pin_in after a two-flop synchroniser, in the same bit layout as R1.
- R3: The output-level banks at 0x06-0x08 can be written directly. pin_out follows them one edge after the write, and a read returns the stored levels.
- R4: At 0x09-0x0B, a 1 written to a bit drives that pin's pin_out high. At 0x0C-0x0E, a 1 written to a bit drives it low. Both use the R1 layout.
- R5: A 0 bit written to a set or clear register leaves that pin's output level unchanged.
- R6: The set and clear registers read as 0x00. Bits for pins at or above the pin count read as 0. Unmapped addresses read as 0x00.
- R7: The control register is at 0x17: bit 0 is card-detect enable for pin 0, bit 1 for pin 1, and bit 2 is module enable. cd_en and mod_on reflect it. While module enable is 0, pin_oe is all zero.
- R8: After reset, all pins are inputs with output level 0, debounce is off, control is 0, every pulldown is selected and no pullup is selected.
- R9: The pull registers are at 0x12-0x16. Pin n uses address 0x12+(n>>2). Bit 2*(n&3) selects its pulldown and bit 2*(n&3)+1 selects its pullup.
- R10: The debounce enables are at 0x0F-0x11 in the R1 layout. A 1 drives deb_en[n] high.
- R11: bus_rdata is registered and changes only after an edge with bus_re high. If a read and a write target the same address in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 18 | Asynchronous pin input levels |
| pin_out | output | 18 | Pin output levels |
| pin_oe | output | 18 | Pin output enables |
| pull_up | output | 18 | Per-pin pull-up select |
| pull_dn | output | 18 | Per-pin pull-down select |
| deb_en | output | 18 | Per-pin debounce enable |
| cd_en | output | 2 | Card-detect enables for pins 0 and 1 |
| mod_on | output | 1 | Module enable |

## Verification
One case needs care: a read and a write aimed at the same register in the same cycle. The bench raises bus_re and bus_we together on the output-level bank. It expects the returned byte to be the level from before the write, and a later plain read to show the new value. It also checks that pin_out has taken the written value by then. A related case is a pin direction that is set while the module enable is off. Here pin_oe must stay low until the enable is written, even though the direction bank already reads back as an output.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;
  localparam int REG_W   = 8;
  localparam int CTRL_W  = 3;
  localparam int CTRL_CD0 = 0;
  localparam int CTRL_CD1 = 1;
  localparam int CTRL_ON  = 2;

  function automatic int bank_count(input int bits, input int per_bank);
    return (bits + per_bank - 1) / per_bank;
  endfunction
endpackage

// File: rtl/gpio_rf_sync.sv
module gpio_rf_sync #(
  parameter int WIDTH  = 18,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_rf_bitbank.sv
// Generic per-bit register spread across consecutive byte addresses:
// bit i is stored at address BASE + i/8, byte lane i%8.
module gpio_rf_bitbank #(
  parameter int                  NUM_BITS  = 18,
  parameter int                  ADDR_W    = 6,
  parameter int                  BASE      = 0,
  parameter logic [NUM_BITS-1:0] RESET_VAL = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  output logic [NUM_BITS-1:0] q
);
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    localparam int BANK = i / 8;
    localparam int LANE = i % 8;
    always_ff @(posedge clk) begin
      if (rst) q[i] <= RESET_VAL[i];
      else if (we && addr == ADDR_W'(BASE + BANK)) q[i] <= wdata[LANE];
    end
  end
endmodule

// File: rtl/gpio_rf_outlatch.sv
// Output-level storage with direct write, write-one-to-set and
// write-one-to-clear byte banks.
module gpio_rf_outlatch #(
  parameter int NUM_PINS = 18,
  parameter int ADDR_W   = 6,
  parameter int A_DATA   = 6,
  parameter int A_SET    = 9,
  parameter int A_CLR    = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  output logic [NUM_PINS-1:0] q
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int BANK = i / 8;
    localparam int LANE = i % 8;
    logic hit_data, hit_set, hit_clr;
    assign hit_data = we && addr == ADDR_W'(A_DATA + BANK);
    assign hit_set  = we && addr == ADDR_W'(A_SET  + BANK) && wdata[LANE];
    assign hit_clr  = we && addr == ADDR_W'(A_CLR  + BANK) && wdata[LANE];
    always_ff @(posedge clk) begin
      if (rst)           q[i] <= 1'b0;
      else if (hit_data) q[i] <= wdata[LANE];
      else if (hit_set)  q[i] <= 1'b1;
      else if (hit_clr)  q[i] <= 1'b0;
    end
  end

  // R4: a one in the set bank raises the pin
  assert_set_raises_R4: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_W'(A_SET) && wdata[0]) |=> q[0]);
  // R4: a one in the clear bank lowers the pin
  assert_clr_lowers_R4: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_W'(A_CLR) && wdata[0]) |=> !q[0]);
  // R5: zero bits in set/clear leave the level alone
  assert_zero_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (we && (addr == ADDR_W'(A_SET) || addr == ADDR_W'(A_CLR)) && !wdata[0])
    |=> $stable(q[0]));
endmodule

// File: rtl/gpio_rf_top.sv
module gpio_rf_top
  import gpio_rf_pkg::*;
#(
  parameter int NUM_PINS    = 18,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  input  logic                bus_we,
  input  logic                bus_re,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pull_up,
  output logic [NUM_PINS-1:0] pull_dn,
  output logic [NUM_PINS-1:0] deb_en,
  output logic [1:0]          cd_en,
  output logic                mod_on
);
  localparam int DBANKS = bank_count(NUM_PINS, REG_W);
  localparam int PBANKS = bank_count(2 * NUM_PINS, REG_W);
  localparam int A_DIR  = 0;
  localparam int A_DIN  = A_DIR  + DBANKS;
  localparam int A_DOUT = A_DIN  + DBANKS;
  localparam int A_SET  = A_DOUT + DBANKS;
  localparam int A_CLR  = A_SET  + DBANKS;
  localparam int A_DEB  = A_CLR  + DBANKS;
  localparam int A_PULL = A_DEB  + DBANKS;
  localparam int A_CTRL = A_PULL + PBANKS;
  localparam logic [2*NUM_PINS-1:0] PULL_RST = {NUM_PINS{2'b01}};

  logic [NUM_PINS-1:0]   dir_q, din_s, dout_q, deb_q, oe_q;
  logic [2*NUM_PINS-1:0] pull_q;
  logic [CTRL_W-1:0]     ctrl_q;
  logic [REG_W-1:0]      rd_next, rdata_q;

  gpio_rf_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(din_s));

  gpio_rf_bitbank #(.NUM_BITS(NUM_PINS), .ADDR_W(ADDR_W), .BASE(A_DIR),
                    .RESET_VAL('0)) u_dir (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .q(dir_q));

  gpio_rf_bitbank #(.NUM_BITS(NUM_PINS), .ADDR_W(ADDR_W), .BASE(A_DEB),
                    .RESET_VAL('0)) u_deb (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .q(deb_q));

  gpio_rf_bitbank #(.NUM_BITS(2*NUM_PINS), .ADDR_W(ADDR_W), .BASE(A_PULL),
                    .RESET_VAL(PULL_RST)) u_pull (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .q(pull_q));

  gpio_rf_outlatch #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .A_DATA(A_DOUT),
                     .A_SET(A_SET), .A_CLR(A_CLR)) u_out (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .q(dout_q));

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (bus_we && bus_addr == ADDR_W'(A_CTRL)) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  // output enables gated by module enable, registered
  always_ff @(posedge clk) begin
    if (rst) oe_q <= '0;
    else     oe_q <= dir_q & {NUM_PINS{ctrl_q[CTRL_ON]}};
  end

  // read mux; set/clear banks and unmapped addresses yield zero
  always_comb begin
    rd_next = '0;
    for (int b = 0; b < DBANKS; b++) begin
      for (int k = 0; k < REG_W; k++) begin
        if (b * REG_W + k < NUM_PINS) begin
          if (bus_addr == ADDR_W'(A_DIR  + b)) rd_next[k] = dir_q[b*REG_W+k];
          if (bus_addr == ADDR_W'(A_DIN  + b)) rd_next[k] = din_s[b*REG_W+k];
          if (bus_addr == ADDR_W'(A_DOUT + b)) rd_next[k] = dout_q[b*REG_W+k];
          if (bus_addr == ADDR_W'(A_DEB  + b)) rd_next[k] = deb_q[b*REG_W+k];
        end
      end
    end
    for (int b = 0; b < PBANKS; b++) begin
      for (int k = 0; k < REG_W; k++) begin
        if (b * REG_W + k < 2 * NUM_PINS && bus_addr == ADDR_W'(A_PULL + b))
          rd_next[k] = pull_q[b*REG_W+k];
      end
    end
    if (bus_addr == ADDR_W'(A_CTRL)) rd_next[CTRL_W-1:0] = ctrl_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_next;
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pull
    assign pull_dn[n] = pull_q[2*n];
    assign pull_up[n] = pull_q[2*n+1];
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = dout_q;
  assign pin_oe    = oe_q;
  assign deb_en    = deb_q;
  assign cd_en     = {ctrl_q[CTRL_CD1], ctrl_q[CTRL_CD0]};
  assign mod_on    = ctrl_q[CTRL_ON];

  // R7: module disabled on the previous edge means no enables now
  assert_oe_gated_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(mod_on) |-> pin_oe == '0);
  // R6: set bank reads as zero
  assert_set_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == ADDR_W'(A_SET)) |=> bus_rdata == '0);
  // R11: read data holds without a read strobe
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));
  // R1: an enabled output pin is marked as output in the direction bank
  assert_oe_needs_dir_R1: assert property (@(posedge clk) disable iff (rst)
    pin_oe[0] |-> $past(dir_q[0]));
endmodule

// File: tb/gpio_rf_top_tb.sv
module gpio_rf_top_tb_top;
  localparam int N = 18;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe, pull_up, pull_dn, deb_en;
  logic [1:0] cd_en;
  logic mod_on;
  int n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  gpio_rf_top dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pull_up(pull_up), .pull_dn(pull_dn), .deb_en(deb_en),
    .cd_en(cd_en), .mod_on(mod_on));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R8 oe", pin_oe, 0);
    chk("R8 out", pin_out, 0);
    chk("R8 pull_dn", pull_dn, 32'h3FFFF);
    chk("R8 pull_up", pull_up, 0);
    chk("R8 deb", deb_en, 0);
    chk("R8 ctrl", {cd_en, mod_on}, 0);
    rd(6'h12, rv); chk("R8 pull reg0", rv, 8'h55);
    rd(6'h16, rv); chk("R6 pull reg4 upper bits", rv, 8'h05);
  endtask

  task automatic t_dir();
    wr(6'h00, 8'hA5); wr(6'h02, 8'hFF); idle(2);
    chk("R7 oe off while disabled", pin_oe, 0);
    rd(6'h00, rv); chk("R1 dir readback", rv, 8'hA5);
    wr(6'h17, 8'h04); idle(2);
    chk("R1 oe", pin_oe, 32'h300A5);
    rd(6'h02, rv); chk("R6 dir bank2 upper zero", rv, 8'h03);
  endtask

  task automatic t_ctrl();
    wr(6'h17, 8'h03); idle(2);
    chk("R7 oe forced low", pin_oe, 0);
    chk("R7 cd_en", cd_en, 2'b11);
    chk("R7 mod_on", mod_on, 0);
    wr(6'h17, 8'h04); idle(2);
    chk("R7 oe restored", pin_oe, 32'h300A5);
  endtask

  task automatic t_dout();
    wr(6'h07, 8'h3C); idle(1);
    chk("R3 direct write", pin_out, 32'h03C00);
    wr(6'h09, 8'h81); idle(1);
    chk("R4 set", pin_out, 32'h03C81);
    wr(6'h0A, 8'h00); idle(1);
    chk("R5 zero set", pin_out, 32'h03C81);
    wr(6'h0D, 8'h0C); idle(1);
    chk("R4 clear", pin_out, 32'h03081);
    wr(6'h0E, 8'h00); idle(1);
    chk("R5 zero clear", pin_out, 32'h03081);
    wr(6'h0B, 8'h02); idle(1);
    chk("R4 set pin17", pin_out, 32'h23081);
    rd(6'h09, rv); chk("R6 set reads zero", rv, 0);
    rd(6'h0C, rv); chk("R6 clear reads zero", rv, 0);
    rd(6'h07, rv); chk("R3 dout readback", rv, 8'h30);
  endtask

  task automatic t_din();
    @(negedge clk); pin_in = 18'h25AC3; idle(3);
    rd(6'h03, rv); chk("R2 din0", rv, 8'hC3);
    rd(6'h04, rv); chk("R2 din1", rv, 8'h5A);
    rd(6'h05, rv); chk("R2 din2", rv, 8'h02);
    wr(6'h03, 8'hFF);
    rd(6'h03, rv); chk("R2 din read-only", rv, 8'hC3);
    rd(6'h20, rv); chk("R6 unmapped", rv, 0);
  endtask

  task automatic t_pull();
    wr(6'h16, 8'h0E); wr(6'h12, 8'h09); idle(1);
    chk("R9 pull_up", pull_up, 32'h30002);
    chk("R9 pull_dn", pull_dn, 32'h2FFF1);
  endtask

  task automatic t_deb();
    wr(6'h10, 8'hF0); idle(1);
    chk("R10 deb", deb_en, 32'h0F000);
    rd(6'h10, rv); chk("R10 deb readback", rv, 8'hF0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk); bus_addr = 6'h06; bus_wdata = 8'h11; bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk); bus_we = 1'b0; bus_re = 1'b0;
    chk("R11 old value on collision", bus_rdata, 8'h81);
    chk("R11 write took effect", pin_out[7:0], 8'h11);
    idle(2);
    chk("R11 rdata held", bus_rdata, 8'h81);
    rd(6'h06, rv); chk("R11 new value", rv, 8'h11);
  endtask

  initial begin
    fork
      begin
        idle(3); rst = 1'b0; idle(1);
        t_reset(); t_dir(); t_ctrl(); t_dout(); t_din();
        t_pull(); t_deb(); t_same_cycle();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule